// File: doc/BRIEF.md
# Three-Wire Configuration Register Loader

This block takes configuration words from a one-way serial bus of three wires: a bit clock, a data line and a frame strobe. The strobe is held low for the length of a frame. On each rising bit-clock edge inside a frame, one bit enters a 16-bit shift register, most significant bit first. No bits are counted. When more than 16 bits arrive, only the newest 16 remain. When the strobe rises, the low four bits of that word are compared with a device address parameter. On a match, a one-cycle load pulse writes the 10-bit data field into one of three bus registers. The two subaddress bits select which register.

The three bus wires are oversampled in the system clock domain through synchronisers. The bus registers can therefore be written at any time, including while the rest of the chip is powered down. A second bank, the forwarded bank, copies the bus registers on every system clock while the power-up input is high. It holds its contents while that input is low.

All control outputs come from the forwarded bank, including the enable and level for an external tri-state pad. The system clock stands for the master clock, so forwarding also needs that clock to be running.

The serial bus has no back-pressure, so the block has no valid/ready interface. Every frame that arrives is decoded, and every output is a plain level.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, every output is 0 and `gp_oe` is 0, so the pad is high-impedance.
- R2: Bits enter MSB first. Only the last 16 bits clocked in before the strobe rises form the word, and any earlier leading bits have no effect.
- R3: Word bits 3..0 are the device address. Only a word whose address equals `DEV_ADDR` (default 4'hA) changes any register. A word with any other address leaves every output unchanged.
- R4: Word bits 15..6 are the data field d9..d0, and bits 5..4 are the subaddress. A loaded word changes only the register it selects:
  - Subaddress 0: d5..d0 = `home_lvl`, d7..d6 = `home_tc`, d8 = `dir_ctrl`, d9 = `test_mode`.
  - Subaddress 1: d7..d0 = `pwr_lvl`, d9..d8 = `lim_code`.
  - Subaddress 2: d5..d0 = `kick_lvl`, d6 = `gain_op`, d7 = `gain_slope`, d8 = pad enable, d9 = pad level.
- R5: A matching word with subaddress 3 changes no register.
- R6: Bit-clock edges while the strobe is high shift nothing. A strobe pulse with no bit clocks reloads the word already held.
- R7: While `pwr_up` is low, outputs hold their values even when registers are written. Once `pwr_up` is high, outputs take the bus register contents within a few system cycles.
- R8: `gp_oe` equals the pad-enable bit (subaddress 2, d8). `gp_out` equals the pad-level bit (d9) when the enable is 1, and is 0 otherwise.
- R9: Registers change only on the rising strobe edge. A full frame clocked in while the strobe is still low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_strobe | input | 1 | Frame strobe; low during a frame, rising edge loads |
| pwr_up | input | 1 | High: forward bus registers to outputs |
| kick_lvl | output | 6 | Kick level |
| home_lvl | output | 6 | Home level |
| home_tc | output | 2 | Home temperature coefficient code |
| pwr_lvl | output | 8 | Power level |
| lim_code | output | 2 | Limiter code |
| dir_ctrl | output | 1 | Direct-control select |
| test_mode | output | 1 | Test select |
| gain_op | output | 1 | Sensor amplifier gain select |
| gain_slope | output | 1 | Slope output gain select |
| gp_out | output | 1 | Pad level for the tri-state pin |
| gp_oe | output | 1 | Pad output enable (0 = high-impedance) |

## Verification
The main function is tried in several ways:
- Directed frames to each subaddress. These confirm that each field lands in the right place and that the other registers stay untouched.
- Frames with a wrong address and frames with subaddress 3. These must be rejected.
- Frames padded with extra leading bits. These tell "last 16 bits win" apart from "first 16 bits win".
- Bit clocks sent while the strobe is high, followed by a bare strobe pulse. This tells a gated shifter apart from a free-running one.
- A frame left open with the strobe still low. This tells load-on-strobe-edge apart from load-on-sixteenth-bit.
- Random frames with mixed addresses, subaddresses, padding and power-up levels, compared against a bench model of both banks. These show that writes made while powered down are held back and then appear once power is up.

// File: rtl/srl_cfg_pkg.sv
package srl_cfg_pkg;
  localparam int KICK_W = 6;
  localparam int HOME_W = 6;
  localparam int TC_W   = 2;
  localparam int PWR_W  = 8;
  localparam int LIM_W  = 2;
  localparam int DATA_W = 10;
  localparam int NREG   = 3;

  // subaddress 0
  typedef struct packed {
    logic              test_mode;
    logic              dir_ctrl;
    logic [TC_W-1:0]   home_tc;
    logic [HOME_W-1:0] home_lvl;
  } home_reg_t;

  // subaddress 1
  typedef struct packed {
    logic [LIM_W-1:0] lim_code;
    logic [PWR_W-1:0] pwr_lvl;
  } pwr_reg_t;

  // subaddress 2
  typedef struct packed {
    logic              pad_lvl;
    logic              pad_en;
    logic              gain_slope;
    logic              gain_op;
    logic [KICK_W-1:0] kick_lvl;
  } kick_reg_t;
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL[b]}};
      else        ff_q <= {ff_q[STAGES-2:0], din[b]};
    end
    assign lvl[b] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/srl_shift.sv
module srl_shift #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              data_s,
  input  logic              strobe_s,
  input  logic              strobe_rise,
  output logic              load_pulse,
  output logic [SUB_W-1:0]  load_sub,
  output logic [DATA_W-1:0] load_data
);
  localparam int SUB_LO  = ADDR_W;
  localparam int DATA_LO = ADDR_W + SUB_W;

  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sh_q <= '0;
    else if (bit_tick && !strobe_s) sh_q <= {sh_q[WORD_W-2:0], data_s};
  end

  assign load_sub   = sh_q[SUB_LO +: SUB_W];
  assign load_data  = sh_q[DATA_LO +: DATA_W];
  assign load_pulse = strobe_rise && (sh_q[ADDR_W-1:0] == DEV_ADDR);
endmodule

// File: rtl/srl_regs.sv
module srl_regs #(
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  parameter int NREG   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_pulse,
  input  logic [SUB_W-1:0]         load_sub,
  input  logic [DATA_W-1:0]        load_data,
  input  logic                     pwr_up,
  output logic [NREG*DATA_W-1:0]   bank_q,
  output logic [NREG*DATA_W-1:0]   shadow_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[i*DATA_W +: DATA_W] <= '0;
      else if (load_pulse && (load_sub == SUB_W'(i)))
        bank_q[i*DATA_W +: DATA_W] <= load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= '0;
    else if (pwr_up) shadow_q <= bank_q;
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import srl_cfg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SUB_W  = 2,
  parameter int ADDR_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  input  logic              pwr_up,
  output logic [KICK_W-1:0] kick_lvl,
  output logic [HOME_W-1:0] home_lvl,
  output logic [TC_W-1:0]   home_tc,
  output logic [PWR_W-1:0]  pwr_lvl,
  output logic [LIM_W-1:0]  lim_code,
  output logic              dir_ctrl,
  output logic              test_mode,
  output logic              gain_op,
  output logic              gain_slope,
  output logic              gp_out,
  output logic              gp_oe
);
  logic [2:0] sync_lvl, sync_rise;
  logic strobe_rise, load_pulse;
  logic [SUB_W-1:0]  load_sub;
  logic [DATA_W-1:0] load_data;
  logic [NREG*DATA_W-1:0] bank_q, shadow_q;
  home_reg_t r_home;
  pwr_reg_t  r_pwr;
  kick_reg_t r_kick;

  // bit order: {strobe, data, clk}; strobe idles high
  srl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ser_strobe, ser_data, ser_clk}),
    .lvl(sync_lvl), .rise(sync_rise)
  );
  assign strobe_rise = sync_rise[2];

  srl_shift #(.WORD_W(WORD_W), .DATA_W(DATA_W), .SUB_W(SUB_W),
              .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_tick(sync_rise[0]), .data_s(sync_lvl[1]),
    .strobe_s(sync_lvl[2]), .strobe_rise(strobe_rise),
    .load_pulse(load_pulse), .load_sub(load_sub), .load_data(load_data)
  );

  srl_regs #(.DATA_W(DATA_W), .SUB_W(SUB_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .load_pulse(load_pulse), .load_sub(load_sub), .load_data(load_data),
    .pwr_up(pwr_up), .bank_q(bank_q), .shadow_q(shadow_q)
  );

  assign r_home = home_reg_t'(shadow_q[0*DATA_W +: DATA_W]);
  assign r_pwr  = pwr_reg_t'(shadow_q[1*DATA_W +: DATA_W]);
  assign r_kick = kick_reg_t'(shadow_q[2*DATA_W +: DATA_W]);

  assign home_lvl   = r_home.home_lvl;
  assign home_tc    = r_home.home_tc;
  assign dir_ctrl   = r_home.dir_ctrl;
  assign test_mode  = r_home.test_mode;
  assign pwr_lvl    = r_pwr.pwr_lvl;
  assign lim_code   = r_pwr.lim_code;
  assign kick_lvl   = r_kick.kick_lvl;
  assign gain_op    = r_kick.gain_op;
  assign gain_slope = r_kick.gain_slope;
  assign gp_oe      = r_kick.pad_en;
  assign gp_out     = r_kick.pad_en & r_kick.pad_lvl;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  parameter int NREG   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pwr_up,
  input logic                   load_pulse,
  input logic [SUB_W-1:0]       load_sub,
  input logic [NREG*DATA_W-1:0] bank_q,
  input logic [NREG*DATA_W-1:0] shadow_q
);
  // R3
  bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(bank_q));

  // R5
  sub3_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && load_sub == SUB_W'(3)) |=> $stable(bank_q));

  // R4
  sub1_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && load_sub == SUB_W'(1)) |=>
      ($stable(bank_q[0 +: DATA_W]) && $stable(bank_q[2*DATA_W +: DATA_W])));

  // R7
  hold_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> $stable(shadow_q));

  // R7
  follow_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> (shadow_q == $past(bank_q)));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.DATA_W(srl_cfg_pkg::DATA_W),
  .SUB_W(SUB_W), .NREG(srl_cfg_pkg::NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .load_pulse(load_pulse),
  .load_sub(load_sub), .bank_q(bank_q), .shadow_q(shadow_q)
);

// File: tb/cfg_serial_loader_bench.sv
`timescale 1ns/1ps
module cfg_serial_loader_bench;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_strobe = 1, pwr_up = 0;
  logic [5:0] kick_lvl, home_lvl;
  logic [1:0] home_tc, lim_code;
  logic [7:0] pwr_lvl;
  logic dir_ctrl, test_mode, gain_op, gain_slope, gp_out, gp_oe;

  int checks = 0, failures = 0;
  logic [9:0] m0 = 0, m1 = 0, m2 = 0;  // bus register model
  logic [9:0] s0 = 0, s1 = 0, s2 = 0;  // forwarded model

  always #10 clk = ~clk;

  cfg_serial_loader u_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .pwr_up(pwr_up),
    .kick_lvl(kick_lvl), .home_lvl(home_lvl), .home_tc(home_tc),
    .pwr_lvl(pwr_lvl), .lim_code(lim_code), .dir_ctrl(dir_ctrl),
    .test_mode(test_mode), .gain_op(gain_op), .gain_slope(gain_slope),
    .gp_out(gp_out), .gp_oe(gp_oe)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_fields();
    return {2'b0, s0, s1, s2[7:0], s2[8], (s2[8] & s2[9])};
  endfunction

  function automatic logic [31:0] got_fields();
    return {2'b0, test_mode, dir_ctrl, home_tc, home_lvl, lim_code, pwr_lvl,
            gain_slope, gain_op, kick_lvl, gp_oe, gp_out};
  endfunction

  task automatic check_all(input string tag);
    chk(tag, got_fields(), exp_fields());
  endtask

  task automatic clock_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_cyc(4); ser_clk = 1;
      wait_cyc(4); ser_clk = 0;
    end
  endtask

  task automatic close_frame();
    wait_cyc(4); ser_strobe = 1; wait_cyc(12);
  endtask

  task automatic send(input logic [31:0] w, input int n);
    ser_strobe = 0; wait_cyc(4);
    clock_bits(w, n);
    close_frame();
  endtask

  function automatic void model(input logic [15:0] w);
    if (w[3:0] == 4'hA) begin
      case (w[5:4])
        2'd0: m0 = w[15:6];
        2'd1: m1 = w[15:6];
        2'd2: m2 = w[15:6];
        default: ;
      endcase
    end
    if (pwr_up) begin s0 = m0; s1 = m1; s2 = m2; end
  endfunction

  function automatic logic [15:0] mk(input logic [9:0] d, input logic [1:0] sub, input logic [3:0] a);
    return {d, sub, a};
  endfunction

  task automatic txm(input logic [15:0] w);
    send({16'h0, w}, 16); model(w);
  endtask

  initial begin : watchdog
    #(20ns * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] w;
    void'($urandom(32'd4242));
    wait_cyc(3); rst_n = 1; wait_cyc(2);
    // R1 reset state
    check_all("R1 reset");

    pwr_up = 1; wait_cyc(3);
    // R4 subaddress 1 fields
    txm(mk({2'd2, 8'hC5}, 2'd1, 4'hA)); check_all("R4 sub1");
    txm(mk({1'b1, 1'b0, 2'd3, 6'h2B}, 2'd0, 4'hA)); check_all("R4 sub0");
    txm(mk({1'b0, 1'b1, 1'b1, 1'b0, 6'h31}, 2'd2, 4'hA)); check_all("R4 sub2");

    // R3 wrong address
    txm(mk(10'h3FF, 2'd1, 4'h5)); check_all("R3 address mismatch");
    txm(mk(10'h155, 2'd0, 4'hB)); check_all("R3 address mismatch near");

    // R5 subaddress 3
    txm(mk(10'h3FF, 2'd3, 4'hA)); check_all("R5 sub3 ignored");

    // R2 leading bits dropped
    w = mk(10'h0A7, 2'd1, 4'hA);
    send({11'h5A5, 5'b10101, w}, 21); model(w); check_all("R2 leading bits");

    // R8 pad drive / release
    txm(mk({1'b1, 1'b1, 2'b00, 6'h05}, 2'd2, 4'hA)); check_all("R8 pad high");
    txm(mk({1'b0, 1'b1, 2'b00, 6'h05}, 2'd2, 4'hA)); check_all("R8 pad low");
    txm(mk({1'b1, 1'b0, 2'b00, 6'h05}, 2'd2, 4'hA)); check_all("R8 pad released");

    // R6 clocks with strobe high do not shift
    w = mk(10'h012, 2'd2, 4'hA);
    txm(w);
    clock_bits({16'h0, mk(10'h3ED, 2'd2, 4'hA)}, 16);
    ser_strobe = 0; wait_cyc(8); close_frame(); model(w);
    check_all("R6 strobe-high clocks ignored");

    // R9 no load before strobe rise
    ser_strobe = 0; wait_cyc(4);
    clock_bits({16'h0, mk(10'h2AA, 2'd1, 4'hA)}, 16);
    wait_cyc(12); check_all("R9 frame open");
    close_frame(); model(mk(10'h2AA, 2'd1, 4'hA)); check_all("R9 after strobe");

    // R7 hold while powered down, forward on power-up
    pwr_up = 0; wait_cyc(3);
    txm(mk(10'h1C3, 2'd0, 4'hA)); check_all("R7 held while down");
    pwr_up = 1; wait_cyc(3); s0 = m0; s1 = m1; s2 = m2;
    check_all("R7 forwarded on power-up");

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [3:0] a;
      int extra;
      pwr_up = ($urandom % 4) != 0; wait_cyc(3);
      if (pwr_up) begin s0 = m0; s1 = m1; s2 = m2; end
      a = ($urandom % 3 == 0) ? 4'($urandom) : 4'hA;
      w = mk(10'($urandom), 2'($urandom), a);
      extra = $urandom % 5;
      send({16'($urandom), w}, 16 + extra); model(w);
      check_all("R2 R3 R4 R5 R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule